// File: doc/BRIEF.md
# Configurable Symmetric Boolean Function Unit

This unit evaluates any symmetric Boolean function of `N_IN` single-bit inputs, meaning a function whose value depends only on how many of the inputs are 1. A regular triangular array of two-input max/min cells forms every threshold signal "at least k inputs are high". Each cell outputs the OR (maximum) and the AND (minimum) of its two inputs. A level of exclusive-OR gates turns each pair of neighbouring thresholds into an exact-count signal.

A runtime index mask with one bit per possible count selects which counts drive the function output high. Software or surrounding logic can therefore change the function every cycle without changing the hardware. The threshold and exact-count vectors are exposed as debug outputs.

A parameter chooses between a purely combinational function output and one captured in a register for timing closure. No adder-based population count is involved anywhere.

Top module: `symfn_unit`

## Requirements
- R1: `ge_vec[0]` equals the OR of all bits of `din` in the same cycle.
- R2: `ge_vec[N_IN-1]` equals the AND of all bits of `din` in the same cycle.
- R3: For every k from 1 to `N_IN`, `ge_vec[k-1]` is 1 exactly when at least k bits of `din` are 1. The vector is therefore a thermometer code: the low c bits are set, where c is the count of ones.
- R4: `eq_vec[k]` (k from 0 to `N_IN`) is 1 exactly when the count of ones in `din` equals k. Exactly one bit of `eq_vec` is set at any time.
- R5: The selected function equals `idx_mask[c]`, where c is the count of ones in `din`. Bit k of `idx_mask` enables count k, and bit 0 enables the all-zero input pattern.
- R6: With `REG_OUT` = 1, `fout` changes only at a rising clock edge and shows the function of the inputs present at that edge. The debug vectors stay combinational.
- R7: With `REG_OUT` = 1, a low `rst_n` clears `fout` to 0 at once, without waiting for a clock edge. `fout` stays 0 until the first rising edge with `rst_n` high.
- R8: With all inputs 0, every `ge_vec` bit is 0, only `eq_vec[0]` is set, and the function is controlled by `idx_mask[0]` alone.
- R9: With all inputs 1, every `ge_vec` bit is 1, only `eq_vec[N_IN]` is set, and the function is controlled by `idx_mask[N_IN]` alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| din | input | N_IN | Input variables |
| idx_mask | input | N_IN+1 | Bit k selects the count-k term |
| ge_vec | output | N_IN | Bit k-1 is the "at least k ones" threshold |
| eq_vec | output | N_IN+1 | Bit k is the "exactly k ones" signal |
| fout | output | 1 | Selected symmetric function |

## Verification
The bench sweeps every input pattern against every mask value. A cascade cell with its carry wired to the wrong row would break the thermometer shape or give a threshold one count off. An exclusive-OR level that pairs the wrong thresholds would light two exact-count bits, or none.

The all-zero and all-one patterns are probed directly. The all-zero case catches a design that forgets the inverted lowest threshold, whose mask bit 0 would then have no effect. The all-one case catches a top count that is wrongly paired into an exclusive-OR.

A mask change just after an edge checks that the registered output holds its old value until the next edge. An asynchronous reset check confirms that the output clears at once and stays clear across an edge taken during reset.

// File: rtl/symfn_pkg.sv
package symfn_pkg;

  // Start offset of column j inside the flat triangular storage.
  // Column j holds j+1 threshold bits.
  function automatic int tri_base(input int j);
    return (j * (j + 1)) / 2;
  endfunction

  // Total number of bits held by a triangular array for n inputs.
  function automatic int tri_size(input int n);
    return (n * (n + 1)) / 2;
  endfunction

endpackage

// File: rtl/symfn_maxmin_cell.sv
module symfn_maxmin_cell (
  input  logic a,
  input  logic b,
  output logic hi,
  output logic lo
);
  // Binary maximum is OR, binary minimum is AND.
  assign hi = a | b;
  assign lo = a & b;
endmodule

// File: rtl/symfn_thresh_array.sv
module symfn_thresh_array
  import symfn_pkg::*;
#(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0] x,
  output logic [N_IN-1:0] ge
);
  localparam int TRI_BITS = tri_size(N_IN);
  localparam int LAST_COL = tri_base(N_IN - 1);

  // Column j occupies bits [tri_base(j) +: j+1].
  // Inside column j, bit k means "at least k+1 of x[0..j] are high".
  logic [TRI_BITS-1:0] tri_bits;

  for (genvar j = 0; j < N_IN; j++) begin : g_col
    if (j == 0) begin : g_first
      assign tri_bits[0] = x[0];
    end else begin : g_cells
      localparam int PREV_BASE = tri_base(j - 1);
      localparam int CUR_BASE  = tri_base(j);

      // Carry travels down the column; it enters as the new variable.
      logic [j:0] cy;
      assign cy[0] = x[j];

      for (genvar k = 0; k < j; k++) begin : g_row
        symfn_maxmin_cell u_cell (
          .a  (cy[k]),
          .b  (tri_bits[PREV_BASE + k]),
          .hi (tri_bits[CUR_BASE + k]),
          .lo (cy[k + 1])
        );
      end

      // The final carry is the new deepest threshold of this column.
      assign tri_bits[CUR_BASE + j] = cy[j];
    end
  end

  assign ge = tri_bits[LAST_COL +: N_IN];
endmodule

// File: rtl/symfn_exact_level.sv
module symfn_exact_level #(
  parameter int N_IN = 4
) (
  input  logic [N_IN-1:0] ge,
  output logic [N_IN:0]   eq
);
  // Count zero: no threshold reached.
  assign eq[0] = ~ge[0];

  // Count k: "at least k" is set and "at least k+1" is not.
  for (genvar k = 1; k < N_IN; k++) begin : g_mid
    assign eq[k] = ge[k - 1] ^ ge[k];
  end

  // Top count: the deepest threshold is used directly.
  assign eq[N_IN] = ge[N_IN - 1];
endmodule

// File: rtl/symfn_index_select.sv
module symfn_index_select #(
  parameter int N_IN = 4
) (
  input  logic [N_IN:0] eq,
  input  logic [N_IN:0] mask,
  output logic          hit
);
  // eq is one-hot, so OR-combining the enabled terms is the same as XOR.
  assign hit = |(eq & mask);
endmodule

// File: rtl/symfn_unit.sv
module symfn_unit #(
  parameter int N_IN    = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] din,
  input  logic [N_IN:0]   idx_mask,
  output logic [N_IN-1:0] ge_vec,
  output logic [N_IN:0]   eq_vec,
  output logic            fout
);
  logic func_comb;

  symfn_thresh_array #(.N_IN(N_IN)) u_thresh (
    .x  (din),
    .ge (ge_vec)
  );

  symfn_exact_level #(.N_IN(N_IN)) u_exact (
    .ge (ge_vec),
    .eq (eq_vec)
  );

  symfn_index_select #(.N_IN(N_IN)) u_sel (
    .eq   (eq_vec),
    .mask (idx_mask),
    .hit  (func_comb)
  );

  if (REG_OUT) begin : g_reg
    logic fout_d;
    logic fout_q;

    always_comb begin
      fout_d = func_comb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fout_q <= 1'b0;
      end else begin
        fout_q <= fout_d;
      end
    end

    assign fout = fout_q;
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst_n;
    assign fout = func_comb;
  end
endmodule

// File: rtl/symfn_unit_chk.sv
module symfn_unit_chk #(
  parameter int N_IN    = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N_IN-1:0] din,
  input logic [N_IN:0]   idx_mask,
  input logic [N_IN-1:0] ge_vec,
  input logic [N_IN:0]   eq_vec,
  input logic            fout
);
  logic past_ok;
  logic rst_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_ff @(posedge clk) begin
    rst_seen <= !rst_n;
  end

  a_r1_or_of_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    ge_vec[0] == (|din));

  a_r2_and_of_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    ge_vec[N_IN-1] == (&din));

  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ge_vec) == $countones(din) &&
    ((ge_vec & (ge_vec >> 1)) == (ge_vec >> 1)));

  a_r4_exact_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(eq_vec) == 1 && eq_vec[$countones(din)]);

  if (REG_OUT) begin : g_reg_chk
    a_r6_registered: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> fout == $past(idx_mask[$countones(din)]));

    a_r7_reset_clear: assert property (@(posedge clk)
      (!rst_n && rst_seen === 1'b1) |-> fout == 1'b0);
  end else begin : g_comb_chk
    a_r5_select: assert property (@(posedge clk) disable iff (!rst_n)
      fout == idx_mask[$countones(din)]);
  end
endmodule

bind symfn_unit symfn_unit_chk #(.N_IN(N_IN), .REG_OUT(REG_OUT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .din      (din),
  .idx_mask (idx_mask),
  .ge_vec   (ge_vec),
  .eq_vec   (eq_vec),
  .fout     (fout)
);

// File: tb/tb_symfn_unit.sv
module tb_symfn_unit;
  localparam int N      = 4;
  localparam int VEC_W  = N + (N + 1) + 1;
  localparam int NVEC   = 8;

  // Each entry is {din, mask, expected function}.
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {4'b0000, 5'b00001, 1'b1},  // R8: zero pattern uses mask bit 0
    {4'b0000, 5'b11110, 1'b0},  // R8: other bits have no effect
    {4'b1111, 5'b10000, 1'b1},  // R9: all ones uses the top bit
    {4'b1111, 5'b01111, 1'b0},  // R9
    {4'b1010, 5'b00100, 1'b1},  // R5: count 2
    {4'b0111, 5'b00100, 1'b0},  // R5: count 3, bit 2 is off
    {4'b0111, 5'b01000, 1'b1},  // R5: count 3
    {4'b1000, 5'b00010, 1'b1}   // R5: count 1
  };

  logic         clk;
  logic         rst_n;
  logic [N-1:0] din;
  logic [N:0]   idx_mask;
  logic [N-1:0] ge_vec;
  logic [N:0]   eq_vec;
  logic         fout;

  int checks;
  int fails;
  bit done;

  symfn_unit #(.N_IN(N), .REG_OUT(1'b1)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .idx_mask (idx_mask),
    .ge_vec   (ge_vec),
    .eq_vec   (eq_vec),
    .fout     (fout)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int popcnt(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, check the combinational vectors, then the
  // registered function one edge later.
  task automatic apply(input logic [N-1:0] d, input logic [N:0] m,
                       input logic exp_f, input bit full);
    int c;
    @(negedge clk);
    din      = d;
    idx_mask = m;
    c = popcnt(d);
    #1;
    if (full) begin
      chk("R1", 32'(ge_vec[0]), 32'(|d));
      chk("R2", 32'(ge_vec[N-1]), 32'(&d));
      chk("R3", 32'(ge_vec), (32'd1 << c) - 32'd1);
      chk("R4", 32'(eq_vec), 32'd1 << c);
    end
    @(negedge clk);
    chk("R5", 32'(fout), 32'(exp_f));
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    din      = '0;
    idx_mask = '1;
    repeat (3) @(posedge clk);
    #1;
    chk("R7", 32'(fout), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Table of directed vectors.
    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][VEC_W-1 -: N], VECS[i][N+1:1], VECS[i][0], 1'b1);
    end

    // Zero and full patterns: debug vectors (R8, R9).
    apply('0, 5'b00001, 1'b1, 1'b0);
    chk("R8", 32'(ge_vec), 32'd0);
    chk("R8", 32'(eq_vec), 32'd1);
    apply('1, 5'b10000, 1'b1, 1'b0);
    chk("R9", 32'(ge_vec), 32'hF);
    chk("R9", 32'(eq_vec), 32'h10);

    // Every pattern against every mask (R5).
    for (int d = 0; d < (1 << N); d++) begin
      for (int m = 0; m < (1 << (N + 1)); m++) begin
        apply(N'(d), (N+1)'(m), m[popcnt(N'(d))], (m == 0));
      end
    end

    // R6: output holds until the next rising edge.
    apply('1, 5'b10000, 1'b1, 1'b0);
    @(negedge clk);
    idx_mask = '0;
    #1;
    chk("R6", 32'(fout), 32'd1);
    @(negedge clk);
    chk("R6", 32'(fout), 32'd0);

    // R7: asynchronous clear mid-cycle, held across an edge.
    idx_mask = '1;
    @(negedge clk);
    chk("R7", 32'(fout), 32'd1);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R7", 32'(fout), 32'd0);
    @(negedge clk);
    chk("R7", 32'(fout), 32'd0);
    rst_n = 1'b1;
    #1;
    chk("R7", 32'(fout), 32'd0);
    @(negedge clk);
    chk("R7", 32'(fout), 32'd1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule